// File: doc/BRIEF.md
# ARINC 429 Transmit Word Queue

This block holds outgoing 32-bit ARINC 429 words between a host register interface and the serializer that drives the bus. The host writes words with a single-cycle push strobe. The block stores them in arrival order and presents the oldest one to the serializer over a valid/ready handshake. The serializer reports back with a one-cycle done pulse once the last bit of a word has left the line. The block reports three status flags: empty, half-full and full. A one-cycle software reset discards everything queued.

A mode input decides when queued words start moving. In automatic mode, transmission begins when the host signals that its load transaction has ended. In command mode, words sit in the queue until the host issues a send command. From then on everything in the queue goes out, including words pushed while that run is still going. Once the queue is empty and the last word has finished, the run ends. Words loaded after that wait for the next trigger.

Top module: `arinc_tx_queue`

## Requirements
- R1: Words leave in the order they were accepted; while `tx_valid` is 1, `tx_data` holds the oldest accepted word not yet taken by a `tx_ready` handshake.
- R2: The queue holds at most 32 words; `full` is 1 exactly when 32 words are stored, and a push while full is discarded.
- R3: `half` is 0 while fewer than 16 words are stored and 1 when 16 or more are stored.
- R4: `empty` is 1 only when no word is stored and no word handed to the serializer is still awaiting its `word_done` pulse.
- R5: With `auto_mode` at 1, a `load_done` pulse starts a run that releases the queued words.
- R6: With `auto_mode` at 0, `tx_valid` stays 0 until a `send_cmd` pulse. That pulse starts a run which also sends words pushed while the run is active.
- R7: A run ends once the queue is empty and the last word is done; words pushed afterwards are held until the next trigger.
- R8: A `sw_reset` pulse discards every stored word, ends any run, and sets `empty` to 1 on the next cycle.
- R9: A push and a handshake in the same cycle are both honoured and leave the stored word count unchanged.
- R10: After `rst_n` is low at a clock edge, `empty` is 1 and `half`, `full` and `tx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_reset | input | 1 | Software clear pulse |
| auto_mode | input | 1 | 1: start on load_done; 0: start on send_cmd |
| push | input | 1 | Host write strobe |
| push_data | input | 32 | Word to queue |
| load_done | input | 1 | End of host load transaction |
| send_cmd | input | 1 | Explicit send command |
| tx_valid | output | 1 | Head word offered to serializer |
| tx_data | output | 32 | Head word |
| tx_ready | input | 1 | Serializer takes the head word |
| word_done | input | 1 | Serializer finished shifting a word |
| empty | output | 1 | Nothing stored or in flight |
| half | output | 1 | 16 or more words stored |
| full | output | 1 | 32 words stored |

## Verification
The bench fills the queue past 32 words. A design that wrapped its write pointer would overwrite the oldest word, and the wrong data would come out first. A directed push-and-pop at 31 words checks the count: one further push must then set `full`, which a design that dropped either operation would miss. The bench holds the serializer busy after the last handshake to check that `empty` stays low until `word_done`; a design that read only the stored count would raise it early. It also checks that words pushed after a drained run stay held, which catches a design that never clears its run state.

// File: rtl/arinc_txq_pkg.sv
// Shared sizing for the ARINC 429 transmit queue.
// Assumes depth is a power of two.
package arinc_txq_pkg;
    localparam int TXQ_DEPTH = 32;
    localparam int TXQ_WIDTH = 32;
endpackage

// File: rtl/txq_store.sv
// Circular word storage with read and write pointers.
// Assumes the caller never writes when full nor reads when empty.
module txq_store #(
    parameter int DEPTH = arinc_txq_pkg::TXQ_DEPTH,
    parameter int WIDTH = arinc_txq_pkg::TXQ_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] head
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    // Advance pointers on accepted write/read; clear returns both to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Capture the pushed word into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/txq_level.sv
// Tracks stored word count and the single word in flight at the serializer.
// Produces empty/half/full flags and the accepted-push qualifier.
// Assumes the serializer accepts a new word only when the previous is done
// or in the same cycle as its done pulse.
module txq_level #(
    parameter int DEPTH = arinc_txq_pkg::TXQ_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     push,
    input  logic                     pop_ok,
    input  logic                     word_done,
    output logic                     push_ok,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     empty,
    output logic                     half,
    output logic                     full,
    output logic                     idle
);
    localparam int CW   = $clog2(DEPTH) + 1;
    localparam int HALF = DEPTH / 2;

    logic in_flight;

    assign full    = (count == CW'(DEPTH));
    assign half    = (count >= CW'(HALF));
    assign push_ok = push && !full;
    assign idle    = (count == '0) && !in_flight;
    assign empty   = idle;

    // Count accepted pushes and handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else begin
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Remember that a word is still being shifted out.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) in_flight <= 1'b0;
        else if (pop_ok)     in_flight <= 1'b1;
        else if (word_done)  in_flight <= 1'b0;
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop_ok && !clear) |=> full);
    p_half_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half) |-> $past(push_ok));
    p_empty_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && !clear) |=> !empty);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (empty && count == '0));
    p_pushpop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok && !clear) |=> $stable(count));
endmodule

// File: rtl/txq_release.sv
// Run control: starts a release run on the mode-selected trigger and ends it
// once the queue and serializer are idle. A trigger wins over the idle end.
module txq_release (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic auto_mode,
    input  logic load_done,
    input  logic send_cmd,
    input  logic idle,
    output logic run
);
    logic start;

    assign start = auto_mode ? load_done : send_cmd;

    // Hold the run flag from trigger until the queue fully drains.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) run <= 1'b0;
        else if (start)      run <= 1'b1;
        else if (idle)       run <= 1'b0;
    end

    p_run_needs_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(load_done || send_cmd));
endmodule

// File: rtl/arinc_tx_queue.sv
// ARINC 429 transmit queue top: storage, level tracking and run control.
// Head word is offered while a run is active and the queue is not empty.
module arinc_tx_queue #(
    parameter int DEPTH = arinc_txq_pkg::TXQ_DEPTH,
    parameter int WIDTH = arinc_txq_pkg::TXQ_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset,
    input  logic             auto_mode,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             load_done,
    input  logic             send_cmd,
    output logic             tx_valid,
    output logic [WIDTH-1:0] tx_data,
    input  logic             tx_ready,
    input  logic             word_done,
    output logic             empty,
    output logic             half,
    output logic             full
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic          push_ok;
    logic          pop_ok;
    logic          idle;
    logic          run;
    logic [CW-1:0] count;

    assign tx_valid = run && (count != '0);
    assign pop_ok   = tx_valid && tx_ready;

    txq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(sw_reset),
        .wr_en(push_ok), .wr_data(push_data),
        .rd_en(pop_ok), .head(tx_data)
    );

    txq_level #(.DEPTH(DEPTH)) u_level (
        .clk(clk), .rst_n(rst_n), .clear(sw_reset),
        .push(push), .pop_ok(pop_ok), .word_done(word_done),
        .push_ok(push_ok), .count(count),
        .empty(empty), .half(half), .full(full), .idle(idle)
    );

    txq_release u_release (
        .clk(clk), .rst_n(rst_n), .clear(sw_reset),
        .auto_mode(auto_mode), .load_done(load_done), .send_cmd(send_cmd),
        .idle(idle), .run(run)
    );

    p_valid_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(load_done || send_cmd || push));
    p_stable_head_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !sw_reset) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: tb/test_arinc_tx_queue.sv
module test_arinc_tx_queue;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_reset = 1'b0;
    logic        auto_mode = 1'b0;
    logic        push = 1'b0;
    logic [31:0] push_data = '0;
    logic        load_done = 1'b0;
    logic        send_cmd = 1'b0;
    logic        tx_ready = 1'b0;
    logic        word_done = 1'b0;
    logic        tx_valid;
    logic [31:0] tx_data;
    logic        empty, half, full;

    always #(PERIOD/2) clk = ~clk;

    arinc_tx_queue i_arinc_tx_queue (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .auto_mode(auto_mode),
        .push(push), .push_data(push_data), .load_done(load_done),
        .send_cmd(send_cmd), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .word_done(word_done),
        .empty(empty), .half(half), .full(full)
    );

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 0;

    // reference model state
    logic [31:0] mq [DEPTH];
    int  mh = 0, mt = 0, mc = 0;
    bit  mrun = 0, minfl = 0;
    // serializer model
    bit  busy = 0;
    int  tmr = 0;
    int  ready_mode = 1;

    function automatic bit m_valid();
        return mrun && (mc != 0);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(empty === (mc == 0 && !minfl), "R4", "empty", 32'(empty), 32'(mc == 0 && !minfl));
        chk(half === (mc >= DEPTH/2), "R3", "half", 32'(half), 32'(mc >= DEPTH/2));
        chk(full === (mc == DEPTH), "R2", "full", 32'(full), 32'(mc == DEPTH));
        chk(tx_valid === m_valid(), auto_mode ? "R5" : "R6", "tx_valid",
            32'(tx_valid), 32'(m_valid()));
        if (m_valid())
            chk(tx_data === mq[mh], "R1", "tx_data", tx_data, mq[mh]);
    endtask

    // One cycle: compare at negedge, drive inputs, update model at posedge.
    task automatic step(input bit p, input bit ld, input bit sc, input bit sr);
        bit done_now, rdy, pop, pok, st, was_idle;
        @(negedge clk);
        compare_all();
        done_now  = busy && (tmr == 0);
        rdy       = ((ready_mode == 2) || (ready_mode == 1 && $urandom_range(1) == 1))
                    && (!busy || done_now);
        push      = p;
        push_data = $urandom;
        load_done = ld;
        send_cmd  = sc;
        sw_reset  = sr;
        tx_ready  = rdy;
        word_done = done_now;
        @(posedge clk);
        pop      = m_valid() && rdy;
        pok      = p && (mc < DEPTH);
        st       = auto_mode ? ld : sc;
        was_idle = (mc == 0) && !minfl;
        if (sr) begin
            mh = 0; mt = 0; mc = 0; mrun = 0; minfl = 0; busy = 0;
        end else begin
            if (pok) begin mq[mt] = push_data; mt = (mt + 1) % DEPTH; end
            if (pop) mh = (mh + 1) % DEPTH;
            mc = mc + (pok ? 1 : 0) - (pop ? 1 : 0);
            if (pop) minfl = 1; else if (done_now) minfl = 0;
            if (st) mrun = 1; else if (was_idle) mrun = 0;
            if (pop) begin busy = 1; tmr = $urandom_range(3); end
            else if (done_now) busy = 0;
            else if (busy) tmr--;
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(empty === 1'b1 && half === 1'b0 && full === 1'b0 && tx_valid === 1'b0,
            "R10", "reset flags", {28'd0, empty, half, full, tx_valid}, 32'h8);
        rst_n = 1'b1;

        // R2/R3/R6: command mode fill past capacity, nothing released
        auto_mode = 0;
        for (int i = 0; i < DEPTH + 3; i++) step(1, 0, 0, 0);
        step(0, 0, 0, 0);
        @(negedge clk);
        chk(full === 1'b1, "R2", "full after overfill", 32'(full), 1);
        chk(tx_valid === 1'b0, "R6", "held without command", 32'(tx_valid), 0);

        // R6: send command, push more during the run, drain
        step(0, 0, 1, 0);
        for (int i = 0; i < 6; i++) step($urandom_range(1) == 1, 0, 0, 0);
        for (int i = 0; i < 600 && (mc != 0 || minfl || mrun); i++) step(0, 0, 0, 0);

        // R7: after drain, new words wait
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0);
        @(negedge clk);
        chk(tx_valid === 1'b0, "R7", "held after drain", 32'(tx_valid), 0);

        // R8: software reset
        step(0, 0, 0, 1);
        step(0, 0, 0, 0);
        @(negedge clk);
        chk(empty === 1'b1 && tx_valid === 1'b0, "R8", "cleared by sw_reset",
            {30'd0, empty, tx_valid}, 32'h2);

        // R9: push and pop together at 31 words
        ready_mode = 0;
        for (int i = 0; i < DEPTH - 1; i++) step(1, 0, 0, 0);
        step(0, 0, 1, 0);
        ready_mode = 2;
        step(1, 0, 0, 0);
        ready_mode = 0;
        step(0, 0, 0, 0);
        @(negedge clk);
        chk(full === 1'b0, "R9", "not full after push+pop", 32'(full), 0);
        step(1, 0, 0, 0);
        @(negedge clk);
        chk(full === 1'b1, "R9", "full after one more push", 32'(full), 1);
        ready_mode = 1;
        for (int i = 0; i < 600 && (mc != 0 || minfl); i++) step(0, 0, 0, 0);
        step(0, 0, 0, 1);

        // R5: automatic mode with random traffic
        auto_mode = 1;
        for (int i = 0; i < 3000; i++)
            step($urandom_range(99) < 45, $urandom_range(99) < 15,
                 $urandom_range(99) < 3, $urandom_range(999) < 3);
        // R6/R7: command mode with random traffic
        auto_mode = 0;
        for (int i = 0; i < 3000; i++)
            step($urandom_range(99) < 45, $urandom_range(99) < 10,
                 $urandom_range(99) < 3, $urandom_range(999) < 3);
        step(0, 0, 0, 0);
        summary();
    end
endmodule